// File: doc/BRIEF.md
# Letterboxed VGA Scan-Out

This block drives a 640x480 VGA raster from a 25.175 MHz pixel clock. It shows an unscaled 512x342 monochrome picture from a byte-wide video SRAM, centred in the frame, with black on all four sides. Horizontal and vertical sync are active low. A single video bit drives the red, green and blue channels together.

The picture is read while the beam scans it. Inside the picture rows, the block starts one SRAM read every 8 pixels. Each read begins two cycles before the first pixel that its byte covers. The byte then feeds a shift register, which sends it out most significant bit first, one bit per pixel. A set bit in memory is a black pixel. The block also has a free-port output. A write path that shares the SRAM uses it to find the cycles in which no display read is active.

Top module: `vls_top`

## Requirements
- R1: While reset is asserted and in the cycle after it, `hsync_n` and `vsync_n` are 1, `video` is 0, `sram_rd` is 0 and `sram_free` is 1.
- R2: Each line lasts H_ACT+H_FP+H_SYNC+H_BP pixels. `hsync_n` is 0 exactly for columns H_ACT+H_FP up to H_ACT+H_FP+H_SYNC-1, and 1 at every other column.
- R3: Each frame lasts V_ACT+V_FP+V_SYNC+V_BP lines. `vsync_n` is 0 exactly for rows V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1, and 1 at every other row.
- R4: `video` is 0 at every raster position outside the window. The window spans columns WIN_X to WIN_X+WIN_W-1 and rows WIN_Y to WIN_Y+WIN_H-1.
- R5: At window position (x, y), measured from the window's top-left corner, `video` equals the inverse of bit 7-(x mod 8) of the byte at address y*(WIN_W/8)+x/8. Bit 7 is the most significant bit. The first window column therefore shows bit 7 of the row's first byte, and the last column shows bit 0 of the row's last byte.
- R6: `sram_rd` is a single-cycle pulse. It is 1 only in window rows, at columns WIN_X-2+8k for k = 0 to WIN_W/8-1.
- R7: During the pulse for fetch k of window row y, `sram_addr` equals y*(WIN_W/8)+k. Consecutive fetches within a frame therefore advance the address by one, starting from 0.
- R8: `sram_free` is 1 in every cycle in which `sram_rd` is 0, including all of blanking, and 0 whenever `sram_rd` is 1.
- R9: The raster, the fetches and the picture repeat identically in every frame with no gap between frames. A new reset restarts the raster at column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sram_data | input | 8 | Read data from video SRAM, valid in the cycle after `sram_rd` |
| sram_addr | output | ADDR_W | Video SRAM read address |
| sram_rd | output | 1 | Display read strobe, one cycle per byte |
| sram_free | output | 1 | SRAM port is not used by the display in this cycle |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | 1 | Pixel level (1 = white) for R, G and B |

## Verification
A wrong column or row counter shows up at once on `hsync_n` or `vsync_n` at the next line or frame boundary, and also moves the `sram_rd` pulses against the expected columns. A wrong fetch lead or shift order corrupts the first pixel of every 8-pixel group, so the left window edge is wrong in the first window row. A stuck or misstepped address counter gives the wrong `sram_addr` on the second fetch of a frame. A wrong pixel polarity shows on the first pixel of the window, because the bench compares every pixel of several frames with a memory pattern that it models itself.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int BYTE_W     = 8;
  localparam int FETCH_LEAD = 2;
endpackage

// File: rtl/vls_counter.sv
module vls_counter #(
  parameter int TOTAL = 800,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = en && (cnt == W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (last) cnt <= '0;
    else if (en)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/vls_fetch.sv
module vls_fetch
  import vls_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_go,
  input  logic              row_done,
  input  logic              frame_start,
  input  logic [BYTE_W-1:0] sram_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_rd,
  output logic              sram_free,
  output logic [BYTE_W-1:0] byte_q
);
  logic [ADDR_W-1:0] row_base, col;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_base  <= '0;
      col       <= '0;
      sram_addr <= '0;
      sram_rd   <= 1'b0;
      sram_free <= 1'b1;
      byte_q    <= '0;
    end else begin
      sram_rd   <= fetch_go;
      sram_free <= !fetch_go;
      if (sram_rd) byte_q <= sram_data;
      if (frame_start) begin
        row_base <= '0;
        col      <= '0;
      end else if (fetch_go) begin
        sram_addr <= row_base + col;
        if (row_done) begin
          row_base <= row_base + ADDR_W'(LINE_BYTES);
          col      <= '0;
        end else begin
          col <= col + ADDR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vls_shift.sv
module vls_shift
  import vls_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              vis,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              video
);
  logic [BYTE_W-1:0] sh;
  logic              cur;

  assign cur = load ? byte_in[BYTE_W-1] : sh[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      video <= 1'b0;
    end else begin
      sh    <= load ? {byte_in[BYTE_W-2:0], 1'b0} : {sh[BYTE_W-2:0], 1'b0};
      video <= vis && !cur;
    end
  end
endmodule

// File: rtl/vls_top.sv
module vls_top
  import vls_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int WIN_X  = 64,
  parameter int WIN_Y  = 69,
  parameter int WIN_W  = 512,
  parameter int WIN_H  = 342,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        sram_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_rd,
  output logic              sram_free,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              video
);
  localparam int HT         = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int VT         = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW         = $clog2(HT);
  localparam int VW         = $clog2(VT);
  localparam int LINE_BYTES = WIN_W / BYTE_W;
  localparam int F_FIRST    = WIN_X - FETCH_LEAD;
  localparam logic [2:0] F_PH = 3'(F_FIRST % BYTE_W);
  localparam logic [2:0] P_PH = 3'(WIN_X % BYTE_W);

  logic [HW-1:0]     hc;
  logic [VW-1:0]     vc;
  logic              h_last, v_last;
  logic              hs_on, vs_on, row_in, col_in;
  logic              fetch_go, row_done, load;
  logic [BYTE_W-1:0] byte_q;

  vls_counter #(.TOTAL(HT), .W(HW)) i_hcnt (
    .clk(clk), .rst(rst), .en(1'b1), .cnt(hc), .last(h_last));
  vls_counter #(.TOTAL(VT), .W(VW)) i_vcnt (
    .clk(clk), .rst(rst), .en(h_last), .cnt(vc), .last(v_last));

  always_comb begin
    hs_on    = (hc >= HW'(H_ACT + H_FP)) && (hc < HW'(H_ACT + H_FP + H_SYNC));
    vs_on    = (vc >= VW'(V_ACT + V_FP)) && (vc < VW'(V_ACT + V_FP + V_SYNC));
    row_in   = (vc >= VW'(WIN_Y)) && (vc < VW'(WIN_Y + WIN_H));
    col_in   = (hc >= HW'(WIN_X)) && (hc < HW'(WIN_X + WIN_W));
    fetch_go = row_in && (hc >= HW'(F_FIRST)) && (hc < HW'(F_FIRST + WIN_W))
               && (hc[2:0] == F_PH);
    row_done = fetch_go && (hc == HW'(F_FIRST + WIN_W - BYTE_W));
    load     = col_in && (hc[2:0] == P_PH);
  end

  vls_fetch #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_fetch (
    .clk(clk), .rst(rst), .fetch_go(fetch_go), .row_done(row_done),
    .frame_start(v_last), .sram_data(sram_data), .sram_addr(sram_addr),
    .sram_rd(sram_rd), .sram_free(sram_free), .byte_q(byte_q));

  vls_shift i_shift (
    .clk(clk), .rst(rst), .load(load), .vis(col_in && row_in),
    .byte_in(byte_q), .video(video));

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      hsync_n <= !hs_on;
      vsync_n <= !vs_on;
    end
  end
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_rd,
  input logic              sram_free,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              video
);
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst)          last_addr <= '0;
    else if (sram_rd) last_addr <= sram_addr;
  end

  p_free_busy_r8: assert property (@(posedge clk) disable iff (rst)
    sram_rd |-> !sram_free);
  p_free_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !sram_rd |-> sram_free);
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    sram_rd |=> !sram_rd);
  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    sram_rd |-> (sram_addr == '0 || sram_addr == last_addr + ADDR_W'(1)));
  p_black_blank_r4: assert property (@(posedge clk) disable iff (rst)
    video |-> (hsync_n && vsync_n));
  p_hsync_width_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |=> !hsync_n);
endmodule

bind vls_top vls_checker #(.ADDR_W(ADDR_W)) i_vls_checker (
  .clk(clk), .rst(rst), .sram_addr(sram_addr), .sram_rd(sram_rd),
  .sram_free(sram_free), .hsync_n(hsync_n), .vsync_n(vsync_n), .video(video));

// File: tb/test_vls_top.sv
module test_vls_top;
  localparam int CLK_PERIOD = 40;
  localparam int H_ACT = 40, H_FP = 4, H_SYNC = 6, H_BP = 6;
  localparam int V_ACT = 20, V_FP = 2, V_SYNC = 2, V_BP = 3;
  localparam int WIN_X = 8, WIN_Y = 6, WIN_W = 16, WIN_H = 5;
  localparam int ADDR_W = 15;
  localparam int HT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int VT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int LB = WIN_W / 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        sram_data;
  logic [ADDR_W-1:0] sram_addr;
  logic              sram_rd, sram_free, hsync_n, vsync_n, video;
  int                pat = 0;
  int                checks = 0;
  int                errors = 0;
  int                pos = 0;
  int                cycles = 0;

  always #(CLK_PERIOD / 2) clk = !clk;
  always @(posedge clk) cycles++;

  function automatic logic [7:0] mem(input int a, input int sel);
    case (sel)
      1:       mem = 8'hFF;
      2:       mem = 8'h00;
      default: mem = 8'((a * 37 + 5) % 256);
    endcase
  endfunction

  always_comb sram_data = mem(int'(sram_addr), pat);

  vls_top #(.H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
            .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
            .WIN_X(WIN_X), .WIN_Y(WIN_Y), .WIN_W(WIN_W), .WIN_H(WIN_H),
            .ADDR_W(ADDR_W)) i_vls_top (
    .clk(clk), .rst(rst), .sram_data(sram_data), .sram_addr(sram_addr),
    .sram_rd(sram_rd), .sram_free(sram_free), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .video(video));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", req, pos, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 hsync_n", int'(hsync_n), 1);
    check("R1 vsync_n", int'(vsync_n), 1);
    check("R1 video", int'(video), 0);
    check("R1 sram_rd", int'(sram_rd), 0);
    check("R1 sram_free", int'(sram_free), 1);
    rst = 1'b0;
    pos = 0;
  endtask

  task automatic t_frames(input int nframes, input int sel);
    pat = sel;
    for (int i = 0; i < nframes * HT * VT; i++) begin
      int h, v, x, y, k;
      bit win, fet;
      @(negedge clk);
      h = pos % HT;
      v = (pos / HT) % VT;
      x = h - WIN_X;
      y = v - WIN_Y;
      win = (x >= 0) && (x < WIN_W) && (y >= 0) && (y < WIN_H);
      k = (h - (WIN_X - 2)) / 8;
      fet = (y >= 0) && (y < WIN_H) && (h >= WIN_X - 2) &&
            (h < WIN_X - 2 + WIN_W) && (((h - (WIN_X - 2)) % 8) == 0);
      check("R2 hsync_n", int'(hsync_n),
            (h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SYNC) ? 0 : 1);
      check("R3 vsync_n", int'(vsync_n),
            (v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SYNC) ? 0 : 1);
      if (win)
        check("R5 R9 pixel", int'(video),
              int'(!mem(y * LB + x / 8, sel)[7 - x % 8]));
      else
        check("R4 border", int'(video), 0);
      check("R6 sram_rd", int'(sram_rd), int'(fet));
      check("R8 sram_free", int'(sram_free), int'(!fet));
      if (fet) check("R7 sram_addr", int'(sram_addr), y * LB + k);
      pos++;
    end
  endtask

  initial begin
    t_reset();
    t_frames(2, 0);
    t_frames(1, 1);
    t_frames(1, 2);
    rst = 1'b1;
    t_reset();
    t_frames(1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule